// File: doc/BRIEF.md
# Clock-Enable Power Mode Tracker

This block follows the power and clock state of a four-bank synchronous DRAM as set by its clock-enable input. On every rising clock edge it pairs the clock-enable level held from the edge before with the level present now, decodes the command lines, and looks at whether any bank has an open row. From those three things it decides whether the device is running normally or sits in clock suspend, idle power-down, open-row power-down or self refresh.

The tracker gives one flag per mode, a gate telling downstream logic whether the internal clock runs, a one-cycle pulse for each recognised auto refresh, and a sticky flag that records any clock-enable sequence the mode rules do not allow. It is intended to sit beside a memory model or controller monitor, so that the rest of the logic can freeze its clocking and buffers while the device is in a low-power state. Timing limits on entry, on exit and on the time spent in self refresh are left to other logic.

Top module: `cke_pwr_tracker`

## Requirements
- R1: After reset the normal flag is 1, the other four mode flags are 0, clk_run_o is 1, illegal_o is 0 and auto_ref_o is 0. Reset takes the previous clock-enable level as high.
- R2: In normal mode, clock enable high at the previous edge and low at this edge, with any bit of bank_open_i set and cs_n_i low, enters clock suspend. The mode holds while clock enable stays low and returns to normal on a low-to-high step.
- R3: In normal mode, a high-to-low step with bank_open_i all zero and cs_n_i high enters idle (precharge) power-down.
- R4: In normal mode, a high-to-low step with any bank open and cs_n_i high enters active power-down.
- R5: auto_ref_o is 1 for exactly the cycle after an edge where the mode is normal, clock enable is high at both edges and the lines read cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R6: In normal mode, a high-to-low step with all banks idle and that same refresh pattern enters self refresh, which holds while clock enable stays low.
- R7: Self refresh returns to normal on a low-to-high step when the lines read a no-op (cs_n=0, ras_n=1, cas_n=1, we_n=1) or a deselect (cs_n=1).
- R8: A low-to-high step in self refresh with any other command keeps self refresh and sets illegal_o.
- R9: Either power-down mode returns to normal on a low-to-high step whatever the command lines read.
- R10: clk_run_o is 1 only in normal mode with clock enable high at the latest edge; a low clock enable at an edge makes it 0 for the following cycle.
- R11: Any step not covered by R2 to R9 (for example a high-to-low step with all banks idle, cs_n low and no refresh pattern, or a low level at both edges in normal mode) leaves the mode unchanged and sets illegal_o, which stays 1 until reset.
- R12: Exactly one mode flag is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock-enable level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bank_open_i | input | NUM_BANKS | One bit per bank, 1 when a row is open |
| normal_o | output | 1 | Normal running mode |
| suspend_o | output | 1 | Clock suspend |
| pre_pd_o | output | 1 | Power-down with all banks idle |
| act_pd_o | output | 1 | Power-down with a row open |
| self_ref_o | output | 1 | Self refresh |
| clk_run_o | output | 1 | Internal clock running |
| auto_ref_o | output | 1 | Auto refresh recognised at the last edge |
| illegal_o | output | 1 | Sticky disallowed-step flag |

## Verification
Every cycle the assertions check that one mode flag is set, that the illegal flag never drops, that a low clock enable stops the clock gate, that each entry condition leads to its mode and each legal wake-up leads back to normal, and that a self-refresh wake-up with a wrong command keeps the mode and raises the flag. The directed scenarios show whole sequences the properties cannot tie together: staying in each mode across several low edges, both accepted self-refresh wake-up commands, the refresh pulse lasting one cycle only, and the illegal flag surviving later legal steps yet clearing on reset.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;
  typedef enum logic [2:0] {
    M_NORMAL  = 3'd0,
    M_SUSPEND = 3'd1,
    M_PRE_PD  = 3'd2,
    M_ACT_PD  = 3'd3,
    M_SELF    = 3'd4
  } pwr_mode_e;

  typedef enum logic [1:0] {
    C_DESEL = 2'd0,
    C_NOP   = 2'd1,
    C_REF   = 2'd2,
    C_OTHER = 2'd3
  } cmd_e;
endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic cke_prev_o
);
  // previous-edge level, taken as high out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_prev_o <= 1'b1;
    else         cke_prev_o <= cke_i;
  end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cke_pwr_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i)                              cmd_o = C_DESEL;
    else if (ras_n_i && cas_n_i && we_n_i)   cmd_o = C_NOP;
    else if (!ras_n_i && !cas_n_i && we_n_i) cmd_o = C_REF;
    else                                     cmd_o = C_OTHER;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import cke_pwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cke_prev_i,
  input  logic      cke_i,
  input  cmd_e      cmd_i,
  input  logic      any_open_i,
  output pwr_mode_e mode_o,
  output logic      clk_run_o,
  output logic      auto_ref_o,
  output logic      illegal_o
);
  pwr_mode_e mode_q, mode_d;
  logic      ill_set;
  logic      ref_d;
  logic      run_q;

  wire hh = cke_prev_i & cke_i;
  wire hl = cke_prev_i & ~cke_i;
  wire lh = ~cke_prev_i & cke_i;
  wire ll = ~cke_prev_i & ~cke_i;

  always_comb begin
    mode_d  = mode_q;
    ill_set = 1'b0;
    unique case (mode_q)
      M_NORMAL: begin
        if (hl) begin
          if (any_open_i)             mode_d = (cmd_i == C_DESEL) ? M_ACT_PD : M_SUSPEND;
          else if (cmd_i == C_DESEL)  mode_d = M_PRE_PD;
          else if (cmd_i == C_REF)    mode_d = M_SELF;
          else                        ill_set = 1'b1;
        end else if (!hh) begin
          ill_set = 1'b1;
        end
      end
      M_SUSPEND, M_PRE_PD, M_ACT_PD: begin
        if (lh)       mode_d = M_NORMAL;
        else if (!ll) ill_set = 1'b1;
      end
      M_SELF: begin
        if (lh) begin
          if (cmd_i == C_NOP || cmd_i == C_DESEL) mode_d = M_NORMAL;
          else                                    ill_set = 1'b1;
        end else if (!ll) begin
          ill_set = 1'b1;
        end
      end
      default: mode_d = M_NORMAL;
    endcase
  end

  assign ref_d = (mode_q == M_NORMAL) && hh && (cmd_i == C_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= M_NORMAL;
      illegal_o  <= 1'b0;
      auto_ref_o <= 1'b0;
      run_q      <= 1'b1;
    end else begin
      mode_q     <= mode_d;
      illegal_o  <= illegal_o | ill_set;
      auto_ref_o <= ref_d;
      run_q      <= cke_i && (mode_d == M_NORMAL);
    end
  end

  assign mode_o    = mode_q;
  assign clk_run_o = run_q;
endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
  import cke_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 normal_o,
  output logic                 suspend_o,
  output logic                 pre_pd_o,
  output logic                 act_pd_o,
  output logic                 self_ref_o,
  output logic                 clk_run_o,
  output logic                 auto_ref_o,
  output logic                 illegal_o
);
  localparam int NUM_MODES = 5;

  logic      cke_prev;
  cmd_e      cmd;
  pwr_mode_e mode;
  logic      any_open;
  logic [NUM_MODES-1:0] mode_vec;

  assign any_open = |bank_open_i;

  cke_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .cke_prev_o (cke_prev)
  );

  cmd_decode u_dec (
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd)
  );

  pwr_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_prev_i (cke_prev),
    .cke_i      (cke_i),
    .cmd_i      (cmd),
    .any_open_i (any_open),
    .mode_o     (mode),
    .clk_run_o  (clk_run_o),
    .auto_ref_o (auto_ref_o),
    .illegal_o  (illegal_o)
  );

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_flag
    assign mode_vec[g] = (mode == pwr_mode_e'(g));
  end

  assign normal_o   = mode_vec[M_NORMAL];
  assign suspend_o  = mode_vec[M_SUSPEND];
  assign pre_pd_o   = mode_vec[M_PRE_PD];
  assign act_pd_o   = mode_vec[M_ACT_PD];
  assign self_ref_o = mode_vec[M_SELF];
endmodule

// File: rtl/cke_pwr_tracker_chk.sv
module cke_pwr_tracker_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 cs_n_i,
  input logic                 ras_n_i,
  input logic                 cas_n_i,
  input logic                 we_n_i,
  input logic [NUM_BANKS-1:0] bank_open_i,
  input logic                 normal_o,
  input logic                 suspend_o,
  input logic                 pre_pd_o,
  input logic                 act_pd_o,
  input logic                 self_ref_o,
  input logic                 clk_run_o,
  input logic                 auto_ref_o,
  input logic                 illegal_o
);
  wire is_ref  = !cs_n_i && !ras_n_i && !cas_n_i && we_n_i;
  wire is_nop  = !cs_n_i && ras_n_i && cas_n_i && we_n_i;
  wire wake_ok = is_nop || cs_n_i;
  wire idle    = (bank_open_i == '0);
  wire hl_norm = normal_o && clk_run_o && !cke_i;

  AST_ONE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({normal_o, suspend_o, pre_pd_o, act_pd_o, self_ref_o}) == 1); // R12
  AST_ILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o); // R11
  AST_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> !clk_run_o); // R10
  AST_SUSP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hl_norm && !idle && !cs_n_i) |=> suspend_o); // R2
  AST_SUSP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_o && cke_i) |=> normal_o); // R2
  AST_PPD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hl_norm && idle && cs_n_i) |=> pre_pd_o); // R3
  AST_APD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hl_norm && !idle && cs_n_i) |=> act_pd_o); // R4
  AST_REF_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_ref_o |-> normal_o); // R5
  AST_SR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hl_norm && idle && is_ref) |=> self_ref_o); // R6
  AST_SR_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && cke_i && wake_ok) |=> normal_o); // R7
  AST_SR_BAD_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_ref_o && cke_i && !wake_ok) |=> (self_ref_o && illegal_o)); // R8
  AST_PD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pre_pd_o || act_pd_o) && cke_i) |=> normal_o); // R9
endmodule

bind cke_pwr_tracker cke_pwr_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/cke_pwr_tracker_tb.sv
module cke_pwr_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  // command codes {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] K_DESEL = 4'b1111;
  localparam logic [3:0] K_NOP   = 4'b0111;
  localparam logic [3:0] K_REF   = 4'b0001;
  localparam logic [3:0] K_ACT   = 4'b0011;
  // mode vector {normal, suspend, pre_pd, act_pd, self_ref}
  localparam logic [4:0] V_NORM = 5'b10000;
  localparam logic [4:0] V_SUSP = 5'b01000;
  localparam logic [4:0] V_PPD  = 5'b00100;
  localparam logic [4:0] V_APD  = 5'b00010;
  localparam logic [4:0] V_SR   = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic [3:0] cmd = K_DESEL;
  logic [NB-1:0] banks = '0;
  logic normal, suspend, pre_pd, act_pd, self_ref, clk_run, auto_ref, illegal;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_pwr_tracker #(.NUM_BANKS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke),
    .cs_n_i(cmd[3]), .ras_n_i(cmd[2]), .cas_n_i(cmd[1]), .we_n_i(cmd[0]),
    .bank_open_i(banks),
    .normal_o(normal), .suspend_o(suspend), .pre_pd_o(pre_pd), .act_pd_o(act_pd),
    .self_ref_o(self_ref), .clk_run_o(clk_run), .auto_ref_o(auto_ref), .illegal_o(illegal)
  );

  wire [4:0] modes = {normal, suspend, pre_pd, act_pd, self_ref};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [4:0] m, input logic run,
                           input logic ill);
    chk(req, {modes, clk_run, illegal, 1'b0}, {m, run, ill, 1'b0});
  endtask

  // drive at falling edge, let one rising edge pass, sample after it
  task automatic step(input logic c, input logic [3:0] k, input logic [NB-1:0] b);
    @(negedge clk);
    cke = c; cmd = k; banks = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cke = 1'b1; cmd = K_DESEL; banks = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1 reset", V_NORM, 1'b1, 1'b0);
    chk("R1 auto_ref", {7'd0, auto_ref}, 8'd0);
  endtask

  task automatic t_auto_ref();
    do_reset();
    step(1'b1, K_REF, '0);
    chk("R5 pulse", {7'd0, auto_ref}, 8'd1);
    chk_state("R5 mode", V_NORM, 1'b1, 1'b0);
    step(1'b1, K_NOP, '0);
    chk("R5 one cycle", {7'd0, auto_ref}, 8'd0);
  endtask

  task automatic t_suspend();
    do_reset();
    step(1'b0, K_NOP, 4'b0010);
    chk_state("R2 R10 enter suspend", V_SUSP, 1'b0, 1'b0);
    step(1'b0, K_ACT, 4'b0010);
    chk_state("R2 hold suspend", V_SUSP, 1'b0, 1'b0);
    step(1'b1, K_NOP, 4'b0010);
    chk_state("R2 R10 leave suspend", V_NORM, 1'b1, 1'b0);
  endtask

  task automatic t_act_pd();
    do_reset();
    step(1'b0, K_DESEL, 4'b1000);
    chk_state("R4 enter active pd", V_APD, 1'b0, 1'b0);
    step(1'b0, K_DESEL, 4'b1000);
    chk_state("R4 hold active pd", V_APD, 1'b0, 1'b0);
    step(1'b1, K_ACT, 4'b1000);
    chk_state("R9 leave active pd", V_NORM, 1'b1, 1'b0);
  endtask

  task automatic t_pre_pd();
    do_reset();
    step(1'b0, K_DESEL, '0);
    chk_state("R3 enter idle pd", V_PPD, 1'b0, 1'b0);
    step(1'b1, K_REF, '0);
    chk_state("R9 leave idle pd", V_NORM, 1'b1, 1'b0);
    chk("R5 no pulse on wake", {7'd0, auto_ref}, 8'd0);
  endtask

  task automatic t_self_ref();
    do_reset();
    step(1'b0, K_REF, '0);
    chk_state("R6 enter self refresh", V_SR, 1'b0, 1'b0);
    chk("R5 no pulse on entry", {7'd0, auto_ref}, 8'd0);
    step(1'b0, K_ACT, '0);
    chk_state("R6 hold self refresh", V_SR, 1'b0, 1'b0);
    step(1'b1, K_NOP, '0);
    chk_state("R7 wake by nop", V_NORM, 1'b1, 1'b0);
    step(1'b0, K_REF, '0);
    step(1'b1, K_DESEL, '0);
    chk_state("R7 wake by deselect", V_NORM, 1'b1, 1'b0);
  endtask

  task automatic t_bad_wake();
    do_reset();
    step(1'b0, K_REF, '0);
    step(1'b1, K_ACT, '0);
    chk_state("R8 bad wake", V_SR, 1'b0, 1'b1);
    step(1'b0, K_NOP, '0);
    chk_state("R11 high-low in self refresh", V_SR, 1'b0, 1'b1);
    step(1'b1, K_NOP, '0);
    chk_state("R11 flag sticky", V_NORM, 1'b1, 1'b1);
    do_reset();
    chk_state("R11 R1 cleared by reset", V_NORM, 1'b1, 1'b0);
  endtask

  task automatic t_illegal_normal();
    do_reset();
    step(1'b0, K_NOP, '0);
    chk_state("R11 idle nop high-low", V_NORM, 1'b0, 1'b1);
    do_reset();
    step(1'b0, K_NOP, '0);
    do_reset();
    step(1'b0, K_ACT, '0);
    chk_state("R11 idle other high-low", V_NORM, 1'b0, 1'b1);
    step(1'b1, K_NOP, '0);
    chk_state("R11 R10 low-high in normal", V_NORM, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_auto_ref();
    t_suspend();
    t_act_pd();
    t_pre_pd();
    t_self_ref();
    t_bad_wake();
    t_illegal_normal();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule